// File: doc/BRIEF.md
# Timer Time-Base Counter

This block is the counting core of a general-purpose timer. A programmable prescaler turns an incoming clock-enable tick into counter steps, and a counter then sweeps in one of three patterns: upward, downward, or center-aligned (up, then down). Each wrap at the end of a sweep is an update event. An update event drives a one-cycle pulse and sets a sticky status flag, and it is the moment at which buffered prescaler and auto-reload settings become active.

Software programs the block through write strobes for the prescaler and auto-reload values, and through level configuration inputs for the mode, the reload buffering, update suppression and counter enable. A restart strobe puts the counter and prescaler back at their start points and always produces an update event. The counter value and the current direction are visible at all times.

Top module: `tbase_unit`

## Requirements
- R1: After synchronous reset the counter is 0, the direction output is 0 (up), and both the update pulse and the status flag are 0.
- R2: Up mode (mode code 0): on each counter step the value rises by one; a step taken at a value equal to or above the active reload value goes to 0 and is an overflow.
- R3: Down mode (mode code 1): on each step the value falls by one; a step taken at 0 loads the active reload value and is an underflow. The direction output is 1 in this mode.
- R4: Center mode (mode code 2): the counter rises from 0; the step taken at reload-minus-one goes to the reload value, is an overflow, and turns the direction output to 1. It then falls, and the step taken at 1 goes to 0, is an underflow, and turns the direction output back to 0.
- R5: With an active prescaler value P, the counter takes one step every P+1 tick cycles.
- R6: A new prescaler value takes effect only at the next update event; until then the current division holds.
- R7: With reload buffering off, a written reload value becomes active on the next cycle.
- R8: With reload buffering on, a written reload value becomes active only at the next update event.
- R9: While update suppression is set, overflows and underflows still wrap the counter but produce no update pulse.
- R10: A restart strobe sets the counter to 0 (up and center modes) or to the reload value (down mode), clears the prescaler count, and produces an update pulse even while update suppression is set.
- R11: The update pulse is high for the one cycle following each update event. The status flag is set at each update event, holds its value, and is cleared by the clear strobe unless an update event occurs in the same cycle.
- R12: The counter holds its value in cycles where the counter enable is low or the tick input is low, unless a restart is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Clock-enable tick feeding the prescaler |
| cfg_mode | input | 2 | Counting pattern: 0 up, 1 down, 2 center |
| cfg_preload | input | 1 | Buffer reload writes until the next update event |
| cfg_upd_dis | input | 1 | Suppress update events from overflow and underflow |
| cfg_cnt_en | input | 1 | Counter enable |
| wr_psc | input | 1 | Prescaler write strobe |
| wr_psc_data | input | PSC_W | Prescaler value (divide by value plus one) |
| wr_arr | input | 1 | Reload write strobe |
| wr_arr_data | input | CNT_W | Reload value |
| sw_update | input | 1 | Restart strobe, forces an update event |
| flag_clr | input | 1 | Clear strobe for the status flag |
| cnt | output | CNT_W | Current counter value |
| dir_down | output | 1 | 1 while counting downward |
| upd_pulse | output | 1 | One-cycle update event pulse |
| ovf_flag | output | 1 | Sticky overflow/underflow status |

## Verification
The checker assumes that the mode input is changed only in a cycle where a restart is requested, so that each step can be judged against a single counting pattern. The checker also assumes that reload writes do not shrink the reload below the running value except at a wrap. The stimulus changes the mode only together with the restart strobe. Reload values are rewritten only when the counter is at or below the new value, and in center mode the reload value is always at least 1.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

    localparam int unsigned DEF_CNT_W = 16;
    localparam int unsigned DEF_PSC_W = 16;

    typedef enum logic [1:0] {
        MODE_UP     = 2'd0,
        MODE_DOWN   = 2'd1,
        MODE_CENTER = 2'd2,
        MODE_RSVD   = 2'd3
    } cnt_mode_e;

    typedef struct packed {
        cnt_mode_e mode;
        logic      preload;
        logic      upd_dis;
        logic      cnt_en;
    } tb_cfg_t;

    // Start point after a restart: downward patterns begin at the reload value
    function automatic logic starts_high(input cnt_mode_e m);
        return (m == MODE_DOWN);
    endfunction

endpackage

// File: rtl/tbase_prescaler.sv
module tbase_prescaler
    import tbase_pkg::*;
#(
    parameter int unsigned PSC_W = DEF_PSC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic             wr,
    input  logic [PSC_W-1:0] wr_data,
    input  logic             uev,
    input  logic             restart,
    output logic             wrap
);
    logic [PSC_W-1:0] psc_buf_q;
    logic [PSC_W-1:0] psc_act_q;
    logic [PSC_W-1:0] pc_q;
    logic             at_end;

    assign at_end = (pc_q >= psc_act_q);
    assign wrap   = tick & run & at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            psc_buf_q <= '0;
        end else if (wr) begin
            psc_buf_q <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            psc_act_q <= '0;
        end else if (uev) begin
            psc_act_q <= psc_buf_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else if (restart) begin
            pc_q <= '0;
        end else if (tick && run) begin
            pc_q <= at_end ? '0 : pc_q + 1'b1;
        end
    end

endmodule

// File: rtl/tbase_reload.sv
module tbase_reload
    import tbase_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             preload,
    input  logic             uev,
    output logic [CNT_W-1:0] arr_buf,
    output logic [CNT_W-1:0] arr_act
);
    logic [CNT_W-1:0] buf_q;
    logic [CNT_W-1:0] act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q <= '1;
        end else if (wr) begin
            buf_q <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '1;
        end else if (wr && !preload) begin
            act_q <= wr_data;
        end else if (uev) begin
            act_q <= buf_q;
        end
    end

    assign arr_buf = buf_q;
    assign arr_act = act_q;

endmodule

// File: rtl/tbase_counter.sv
module tbase_counter
    import tbase_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_mode_e        mode,
    input  logic             step,
    input  logic             restart,
    input  logic [CNT_W-1:0] arr_act,
    input  logic [CNT_W-1:0] arr_start,
    output logic [CNT_W-1:0] cnt,
    output logic             dir_down,
    output logic             hw_event
);
    logic [CNT_W-1:0] cnt_q;
    logic             dir_q;
    logic [CNT_W-1:0] nxt_cnt;
    logic             nxt_dir;
    logic             wrap_hit;

    always_comb begin
        nxt_cnt  = cnt_q;
        nxt_dir  = dir_q;
        wrap_hit = 1'b0;
        case (mode)
            MODE_DOWN: begin
                if (cnt_q == '0) begin
                    nxt_cnt  = arr_act;
                    wrap_hit = 1'b1;
                end else begin
                    nxt_cnt = cnt_q - 1'b1;
                end
            end
            MODE_CENTER: begin
                if (arr_act == '0) begin
                    nxt_cnt  = '0;
                    nxt_dir  = 1'b0;
                    wrap_hit = 1'b1;
                end else if (!dir_q) begin
                    if (cnt_q >= arr_act - 1'b1) begin
                        nxt_cnt  = arr_act;
                        nxt_dir  = 1'b1;
                        wrap_hit = 1'b1;
                    end else begin
                        nxt_cnt = cnt_q + 1'b1;
                    end
                end else begin
                    if (cnt_q <= {{(CNT_W-1){1'b0}}, 1'b1}) begin
                        nxt_cnt  = '0;
                        nxt_dir  = 1'b0;
                        wrap_hit = 1'b1;
                    end else begin
                        nxt_cnt = cnt_q - 1'b1;
                    end
                end
            end
            default: begin
                if (cnt_q >= arr_act) begin
                    nxt_cnt  = '0;
                    wrap_hit = 1'b1;
                end else begin
                    nxt_cnt = cnt_q + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            dir_q <= 1'b0;
        end else if (restart) begin
            cnt_q <= starts_high(mode) ? arr_start : '0;
            dir_q <= 1'b0;
        end else if (step) begin
            cnt_q <= nxt_cnt;
            dir_q <= nxt_dir;
        end
    end

    assign hw_event = step & wrap_hit;
    assign cnt      = cnt_q;
    assign dir_down = (mode == MODE_DOWN) ? 1'b1 :
                      (mode == MODE_CENTER) ? dir_q : 1'b0;

endmodule

// File: rtl/tbase_unit.sv
module tbase_unit
    import tbase_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W,
    parameter int unsigned PSC_W = DEF_PSC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_preload,
    input  logic             cfg_upd_dis,
    input  logic             cfg_cnt_en,
    input  logic             wr_psc,
    input  logic [PSC_W-1:0] wr_psc_data,
    input  logic             wr_arr,
    input  logic [CNT_W-1:0] wr_arr_data,
    input  logic             sw_update,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             dir_down,
    output logic             upd_pulse,
    output logic             ovf_flag
);
    tb_cfg_t          cfg;
    logic             step;
    logic             hw_event;
    logic             uev;
    logic [CNT_W-1:0] arr_buf;
    logic [CNT_W-1:0] arr_act;
    logic             upd_q;
    logic             flag_q;

    assign cfg.mode    = cnt_mode_e'(cfg_mode);
    assign cfg.preload = cfg_preload;
    assign cfg.upd_dis = cfg_upd_dis;
    assign cfg.cnt_en  = cfg_cnt_en;

    assign uev = (hw_event & ~cfg.upd_dis) | sw_update;

    tbase_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .run     (cfg.cnt_en),
        .wr      (wr_psc),
        .wr_data (wr_psc_data),
        .uev     (uev),
        .restart (sw_update),
        .wrap    (step)
    );

    tbase_reload #(.CNT_W(CNT_W)) u_arr (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr_arr),
        .wr_data (wr_arr_data),
        .preload (cfg.preload),
        .uev     (uev),
        .arr_buf (arr_buf),
        .arr_act (arr_act)
    );

    tbase_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .mode      (cfg.mode),
        .step      (step),
        .restart   (sw_update),
        .arr_act   (arr_act),
        .arr_start (arr_buf),
        .cnt       (cnt),
        .dir_down  (dir_down),
        .hw_event  (hw_event)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            upd_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            upd_q <= uev;
            if (uev) begin
                flag_q <= 1'b1;
            end else if (flag_clr) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign upd_pulse = upd_q;
    assign ovf_flag  = flag_q;

endmodule

// File: rtl/tbase_unit_chk.sv
module tbase_unit_chk
    import tbase_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic [1:0]       cfg_mode,
    input logic             cfg_upd_dis,
    input logic             cfg_cnt_en,
    input logic             sw_update,
    input logic             flag_clr,
    input logic [CNT_W-1:0] cnt,
    input logic             upd_pulse,
    input logic             ovf_flag
);
    a_r1_reset_clean: assert property (@(posedge clk)
        $past(rst) |-> (!upd_pulse && !ovf_flag));

    a_r2_up_steps: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == MODE_UP && !sw_update) |=>
        (cnt == '0 || cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

    a_r3_down_steps: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == MODE_DOWN && !sw_update && cnt != '0) |=>
        (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1));

    a_r9_no_pulse_when_off: assert property (@(posedge clk) disable iff (rst)
        (cfg_upd_dis && !sw_update) |=> !upd_pulse);

    a_r10_restart_pulse: assert property (@(posedge clk) disable iff (rst)
        sw_update |=> upd_pulse);

    a_r10_restart_zero: assert property (@(posedge clk) disable iff (rst)
        (sw_update && cfg_mode != MODE_DOWN) |=> (cnt == '0));

    a_r11_flag_follows_pulse: assert property (@(posedge clk) disable iff (rst)
        upd_pulse |-> ovf_flag);

    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !flag_clr) |=> ovf_flag);

    a_r11_flag_cleared: assert property (@(posedge clk) disable iff (rst)
        flag_clr |=> (ovf_flag == upd_pulse));

    a_r12_hold_no_enable: assert property (@(posedge clk) disable iff (rst)
        ((!cfg_cnt_en || !tick) && !sw_update) |=> $stable(cnt));

endmodule

bind tbase_unit tbase_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .cfg_mode    (cfg_mode),
    .cfg_upd_dis (cfg_upd_dis),
    .cfg_cnt_en  (cfg_cnt_en),
    .sw_update   (sw_update),
    .flag_clr    (flag_clr),
    .cnt         (cnt),
    .upd_pulse   (upd_pulse),
    .ovf_flag    (ovf_flag)
);

// File: tb/tbase_unit_tb.sv
module tbase_unit_tb;
    localparam int unsigned CNT_W = 16;
    localparam int unsigned PSC_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             tick = 1'b1;
    logic [1:0]       cfg_mode = 2'd0;
    logic             cfg_preload = 1'b0;
    logic             cfg_upd_dis = 1'b0;
    logic             cfg_cnt_en = 1'b0;
    logic             wr_psc = 1'b0;
    logic [PSC_W-1:0] wr_psc_data = '0;
    logic             wr_arr = 1'b0;
    logic [CNT_W-1:0] wr_arr_data = '0;
    logic             sw_update = 1'b0;
    logic             flag_clr = 1'b0;
    logic [CNT_W-1:0] cnt;
    logic             dir_down;
    logic             upd_pulse;
    logic             ovf_flag;

    int n_checks = 0;
    int n_fail = 0;

    typedef struct {
        int    value;
        bit    down;
        bit    pulse;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    always #4 clk = ~clk;

    tbase_unit #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_dut (
        .clk(clk), .rst(rst), .tick(tick), .cfg_mode(cfg_mode),
        .cfg_preload(cfg_preload), .cfg_upd_dis(cfg_upd_dis),
        .cfg_cnt_en(cfg_cnt_en), .wr_psc(wr_psc), .wr_psc_data(wr_psc_data),
        .wr_arr(wr_arr), .wr_arr_data(wr_arr_data), .sw_update(sw_update),
        .flag_clr(flag_clr), .cnt(cnt), .dir_down(dir_down),
        .upd_pulse(upd_pulse), .ovf_flag(ovf_flag)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic push(input int v, input bit d, input bit p, input string tag);
        exp_t e;
        e.value = v; e.down = d; e.pulse = p; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compares one expected item per cycle, away from the clock edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(int'(cnt) == e.value, {e.tag, " count"}, int'(cnt), e.value);
                check(dir_down == e.down, {e.tag, " direction"}, int'(dir_down), int'(e.down));
                check(upd_pulse == e.pulse, {e.tag, " pulse"}, int'(upd_pulse), int'(e.pulse));
            end
        end
    end

    task automatic write_arr(input int v);
        @(negedge clk);
        wr_arr = 1'b1; wr_arr_data = CNT_W'(v);
        @(negedge clk);
        wr_arr = 1'b0;
    endtask

    task automatic write_psc(input int v);
        @(negedge clk);
        wr_psc = 1'b1; wr_psc_data = PSC_W'(v);
        @(negedge clk);
        wr_psc = 1'b0;
    endtask

    // Driver: restart in the given mode; expected items must be pushed just after
    task automatic kick_start(input logic [1:0] m);
        @(negedge clk);
        cfg_mode = m;
        sw_update = 1'b1;
    endtask

    task automatic kick_end();
        @(negedge clk);
        sw_update = 1'b0;
    endtask

    task automatic drain();
        wait (exp_q.size() == 0);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int hold_v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cnt == '0, "R1 count", int'(cnt), 0);
        check(dir_down == 1'b0, "R1 direction", int'(dir_down), 0);
        check(upd_pulse == 1'b0, "R1 pulse", int'(upd_pulse), 0);
        check(ovf_flag == 1'b0, "R1 flag", int'(ovf_flag), 0);
        cfg_cnt_en = 1'b1;

        // R2: up mode, reload 3
        write_arr(3);
        kick_start(2'd0);
        push(0,0,1,"R2"); push(1,0,0,"R2"); push(2,0,0,"R2"); push(3,0,0,"R2");
        push(0,0,1,"R2"); push(1,0,0,"R2"); push(2,0,0,"R2"); push(3,0,0,"R2");
        push(0,0,1,"R2");
        kick_end();
        drain();

        // R3: down mode, reload 3
        kick_start(2'd1);
        push(3,1,1,"R3 R10"); push(2,1,0,"R3"); push(1,1,0,"R3"); push(0,1,0,"R3");
        push(3,1,1,"R3"); push(2,1,0,"R3");
        kick_end();
        drain();

        // R4: center mode, reload 3
        kick_start(2'd2);
        push(0,0,1,"R4"); push(1,0,0,"R4"); push(2,0,0,"R4"); push(3,1,1,"R4");
        push(2,1,0,"R4"); push(1,1,0,"R4"); push(0,0,1,"R4"); push(1,0,0,"R4");
        push(2,0,0,"R4"); push(3,1,1,"R4");
        kick_end();
        drain();

        // R5 and R6: prescaler 2 divides by 3; a rewrite to 0 waits for the wrap
        write_arr(2);
        write_psc(2);
        kick_start(2'd0);
        push(0,0,1,"R5"); push(0,0,0,"R5"); push(0,0,0,"R5");
        push(1,0,0,"R5 R6"); push(1,0,0,"R5 R6"); push(1,0,0,"R5 R6");
        push(2,0,0,"R5 R6"); push(2,0,0,"R5 R6"); push(2,0,0,"R5 R6");
        push(0,0,1,"R6"); push(1,0,0,"R6"); push(2,0,0,"R6"); push(0,0,1,"R6");
        kick_end();
        @(negedge clk);
        wr_psc = 1'b1; wr_psc_data = '0;
        @(negedge clk);
        wr_psc = 1'b0;
        drain();

        // R7: buffering off, reload change applies on the next cycle
        write_arr(3);
        kick_start(2'd0);
        push(0,0,1,"R7"); push(1,0,0,"R7"); push(0,0,1,"R7"); push(1,0,0,"R7");
        push(0,0,1,"R7");
        @(negedge clk);
        sw_update = 1'b0;
        wr_arr = 1'b1; wr_arr_data = CNT_W'(1);
        @(negedge clk);
        wr_arr = 1'b0;
        drain();

        // R8: buffering on, reload change waits for the update event
        cfg_preload = 1'b1;
        write_arr(3);
        kick_start(2'd0);
        push(0,0,1,"R8"); push(1,0,0,"R8"); push(2,0,0,"R8"); push(3,0,0,"R8");
        push(0,0,1,"R8"); push(1,0,0,"R8"); push(0,0,1,"R8"); push(1,0,0,"R8");
        push(0,0,1,"R8");
        kick_end();
        @(negedge clk);
        wr_arr = 1'b1; wr_arr_data = CNT_W'(1);
        @(negedge clk);
        wr_arr = 1'b0;
        drain();
        cfg_preload = 1'b0;
        write_arr(2);

        // R9 and R10: suppression hides wraps but not the restart
        cfg_upd_dis = 1'b1;
        kick_start(2'd0);
        push(0,0,1,"R10"); push(1,0,0,"R9"); push(2,0,0,"R9"); push(0,0,0,"R9");
        push(1,0,0,"R9"); push(2,0,0,"R9"); push(0,0,0,"R9");
        kick_end();
        drain();

        // R11: clear the flag while no events occur
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check(ovf_flag == 1'b0, "R11 cleared", int'(ovf_flag), 0);
        repeat (4) @(negedge clk);
        check(ovf_flag == 1'b0, "R11 stays clear", int'(ovf_flag), 0);
        cfg_upd_dis = 1'b0;
        repeat (4) @(negedge clk);
        check(ovf_flag == 1'b1, "R11 set by wrap", int'(ovf_flag), 1);

        // R10: restart mid-count returns to 0
        write_arr(5);
        kick_start(2'd0);
        push(0,0,1,"R10"); push(1,0,0,"R10"); push(2,0,0,"R10");
        kick_end();
        drain();
        kick_start(2'd0);
        push(0,0,1,"R10 mid"); push(1,0,0,"R10 mid");
        kick_end();
        drain();

        // R12: enable low holds the value
        cfg_cnt_en = 1'b0;
        @(negedge clk);
        hold_v = int'(cnt);
        repeat (4) @(negedge clk);
        check(int'(cnt) == hold_v, "R12 enable low", int'(cnt), hold_v);
        // R12: tick low holds the value
        cfg_cnt_en = 1'b1;
        tick = 1'b0;
        @(negedge clk);
        hold_v = int'(cnt);
        repeat (4) @(negedge clk);
        check(int'(cnt) == hold_v, "R12 tick low", int'(cnt), hold_v);
        tick = 1'b1;
        @(negedge clk);
        check(int'(cnt) != hold_v, "R12 resumes", int'(cnt), hold_v + 1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule